// File: doc/BRIEF.md
# Processor Interrupt Entry Sequencer

This block sits beside the control unit of an 8-bit processor core and decides, at each instruction boundary, whether the core should stop its normal instruction flow and enter an interrupt handler. It watches a level-sensitive maskable request line, an edge-sensitive non-maskable line and a set-overflow pin. It also receives the core's current status byte, return address and stack pointer. When it accepts an interrupt it runs the entry sequence on a simple request/acknowledge memory bus. The sequence pushes the return address and the status byte onto the stack, then fetches the handler address from the vector pair. It hands the new program counter, stack pointer and status byte back to the core.

The core owns the status register and loads `status_upd` whenever `status_we` is high. The sequencer uses that path for two things. It sets the interrupt-disable flag when an entry completes. It sets the overflow flag when the set-overflow pin is released. A one-cycle acknowledge pulse tells the maskable source that its request has been served. `entry_len` reports how many clocks the last entry took.

Top module: `irq_entry_seq`

## Requirements
- R1: The non-maskable line is edge-triggered. A low-to-high change latches a request, which is served at the next instruction boundary whatever the disable flag (status bit 2) holds. Keeping the line high over any number of boundaries yields no further entry.
- R2: A low-to-high change of `irq_req` only marks a maskable request pending. The entry starts at a later `boundary` pulse, and only when status bit 2 is 0 at that pulse.
- R3: When `boundary` arrives with `cli_done` high, no maskable entry starts at that boundary. The pending mark is then set to the current level of `irq_req`, so a still-high line is served at the following boundary.
- R4: An entry writes three bytes on the bus in this order: the high byte of `pc_in`, the low byte of `pc_in`, then `status_in` with bit 4 forced to 0.
- R5: After the three writes the sequencer reads the vector low byte, then the high byte. The vector is at FFFE/FFFF for a maskable entry and at FFFA/FFFB for a non-maskable one. The two bytes appear as `pc_new` with the `entry_done` pulse, in the same cycle that `status_we` sets status bit 2.
- R6: With `bus_ack` held high, an entry keeps `entry_busy` high for exactly 7 cycles, counted from the cycle after the accepting boundary. `entry_done` is a one-cycle pulse in the cycle after the last read, and `entry_len` then reads 7.
- R7: A high-to-low change of `so_pin` raises `status_we` in that cycle, with `status_upd` equal to `status_in` with bit 6 set. A steady pin or a rising pin changes nothing.
- R8: `irq_ack` pulses for one cycle, together with `entry_done`, only when a maskable entry completes.
- R9: Every boundary that runs the maskable check clears the pending mark, even if the disable flag blocked the entry. A later boundary with the flag clear then takes no entry without a new edge.
- R10: Each push goes to address 0x0100 + stack pointer. The pointer starts at `sp_in` and is decremented after each push, so `sp_new` equals `sp_in` − 3.
- R11: If a non-maskable request and a pending maskable request meet at one boundary, the non-maskable entry runs first. The maskable request stays pending for a later boundary.
- R12: Each bus step holds its request and address until `bus_ack` is high. `entry_len` counts the stalled cycles as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Maskable interrupt request, level |
| nmi_line | input | 1 | Non-maskable interrupt line, rising edge |
| so_pin | input | 1 | Set-overflow pin, falling edge sets bit 6 |
| boundary | input | 1 | One-cycle instruction-boundary strobe |
| cli_done | input | 1 | Instruction just finished cleared the disable flag |
| status_in | input | 8 | Current status byte of the core |
| pc_in | input | 16 | Return address, sampled when an entry is accepted |
| sp_in | input | 8 | Stack pointer, sampled when an entry is accepted |
| bus_ack | input | 1 | Bus completes the current access |
| bus_rdata | input | 8 | Bus read data |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | 16 | Access address |
| bus_wdata | output | 8 | Write data |
| status_we | output | 1 | Core loads `status_upd` into its status byte |
| status_upd | output | 8 | Updated status byte |
| sp_new | output | 8 | Stack pointer after the pushes |
| pc_new | output | 16 | Handler address, valid with `entry_done` |
| entry_done | output | 1 | One-cycle pulse when an entry completes |
| irq_ack | output | 1 | One-cycle pulse when a maskable entry completes |
| entry_busy | output | 1 | Entry sequence in progress |
| entry_len | output | 6 | Clocks taken by the most recent entry |

## Verification
The bound checker watches these properties on every cycle:
- bus requests occur only while an entry is busy;
- a stalled access keeps its request and address;
- consecutive pushes step down through the stack;
- reads fall only inside the vector area;
- the done and acknowledge pulses last one cycle;
- a falling overflow pin sets bit 6 and leaves every other status bit as it was.

Only the bench's scenarios can show the decisions that depend on history. These are the single entry for a held non-maskable line, the one-boundary delay after the disable flag is cleared, the pending mark lost at a blocked boundary, and the order in which simultaneous requests are served. A cycle-accurate model in the bench also checks the byte values pushed and the resulting handler address.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 16;

    localparam int FLAG_I = 2;
    localparam int FLAG_B = 4;
    localparam int FLAG_V = 6;

    localparam logic [ADDR_W-1:0] VEC_NMI  = 16'hFFFA;
    localparam logic [ADDR_W-1:0] VEC_MASK = 16'hFFFE;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEAD,
        ST_PUSH_H,
        ST_PUSH_L,
        ST_PUSH_P,
        ST_VEC_L,
        ST_VEC_H
    } step_t;

    typedef enum logic {
        SRC_MASK = 1'b0,
        SRC_NMI  = 1'b1
    } src_t;

    typedef struct packed {
        logic start;
        src_t src;
    } launch_t;

    function automatic logic [ADDR_W-1:0] vec_base(src_t s);
        return (s == SRC_NMI) ? VEC_NMI : VEC_MASK;
    endfunction

    function automatic logic [ADDR_W-1:0] stack_addr(logic [BYTE_W-1:0] page,
                                                     logic [BYTE_W-1:0] sp);
        return {page, sp};
    endfunction

    function automatic logic [BYTE_W-1:0] push_status(logic [BYTE_W-1:0] st);
        logic [BYTE_W-1:0] r;
        r = st;
        r[FLAG_B] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/irq_seq_arbiter.sv
module irq_seq_arbiter
    import irq_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    irq_req,
    input  logic    nmi_line,
    input  logic    boundary,
    input  logic    cli_done,
    input  logic    i_flag,
    input  logic    busy,
    output launch_t launch
);

    logic nmi_prev, irq_prev;
    logic nmi_pend, irq_pend;
    logic nmi_rise, irq_rise;
    logic check, take_nmi, take_irq;
    logic nmi_pend_d, irq_pend_d;

    always_comb begin
        nmi_rise = nmi_line & ~nmi_prev;
        irq_rise = irq_req & ~irq_prev;
        check    = boundary & ~busy;
        take_nmi = check & nmi_pend;
        take_irq = check & ~nmi_pend & ~cli_done & irq_pend & ~i_flag;

        nmi_pend_d = (nmi_pend & ~take_nmi) | nmi_rise;
        if (check && !nmi_pend)
            irq_pend_d = (cli_done & irq_req) | irq_rise;
        else
            irq_pend_d = irq_pend | irq_rise;

        launch.start = take_nmi | take_irq;
        launch.src   = take_nmi ? SRC_NMI : SRC_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_prev <= 1'b0;
            irq_prev <= 1'b0;
            nmi_pend <= 1'b0;
            irq_pend <= 1'b0;
        end else begin
            nmi_prev <= nmi_line;
            irq_prev <= irq_req;
            nmi_pend <= nmi_pend_d;
            irq_pend <= irq_pend_d;
        end
    end

endmodule

// File: rtl/irq_seq_engine.sv
module irq_seq_engine
    import irq_seq_pkg::*;
#(
    parameter int              ENTRY_COST = 7,
    parameter logic [7:0]      STACK_PAGE = 8'h01,
    parameter int              LEN_W      = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  launch_t            launch,
    input  logic [ADDR_W-1:0]  pc_in,
    input  logic [BYTE_W-1:0]  sp_in,
    input  logic [BYTE_W-1:0]  status_in,
    input  logic               bus_ack,
    input  logic [BYTE_W-1:0]  bus_rdata,
    output logic               bus_req,
    output logic               bus_we,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [BYTE_W-1:0]  bus_wdata,
    output logic               busy,
    output logic               done,
    output logic               ack_mask,
    output logic [ADDR_W-1:0]  pc_new,
    output logic [BYTE_W-1:0]  sp_new,
    output logic [LEN_W-1:0]   entry_len
);

    localparam int DEAD_CYC = ENTRY_COST - 5;
    localparam int CNT_W    = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;

    step_t              step;
    src_t               src_q;
    logic [CNT_W-1:0]   wait_cnt;
    logic [ADDR_W-1:0]  pc_q;
    logic [BYTE_W-1:0]  sp_q;
    logic [BYTE_W-1:0]  vec_lo;
    logic [LEN_W-1:0]   run;
    logic               last;

    assign busy   = (step != ST_IDLE);
    assign sp_new = sp_q;
    assign last   = (step == ST_VEC_H) && bus_ack;

    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        unique case (step)
            ST_PUSH_H: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = stack_addr(STACK_PAGE, sp_q);
                bus_wdata = pc_q[ADDR_W-1:BYTE_W];
            end
            ST_PUSH_L: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = stack_addr(STACK_PAGE, sp_q);
                bus_wdata = pc_q[BYTE_W-1:0];
            end
            ST_PUSH_P: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = stack_addr(STACK_PAGE, sp_q);
                bus_wdata = push_status(status_in);
            end
            ST_VEC_L: begin
                bus_req  = 1'b1;
                bus_addr = vec_base(src_q);
            end
            ST_VEC_H: begin
                bus_req  = 1'b1;
                bus_addr = vec_base(src_q) | 16'h0001;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step      <= ST_IDLE;
            src_q     <= SRC_MASK;
            wait_cnt  <= '0;
            pc_q      <= '0;
            sp_q      <= '0;
            vec_lo    <= '0;
            run       <= '0;
            pc_new    <= '0;
            entry_len <= '0;
            done      <= 1'b0;
            ack_mask  <= 1'b0;
        end else begin
            done     <= last;
            ack_mask <= last && (src_q == SRC_MASK);
            if (step != ST_IDLE)
                run <= run + 1'b1;
            unique case (step)
                ST_IDLE: begin
                    if (launch.start) begin
                        step     <= ST_DEAD;
                        wait_cnt <= CNT_W'(DEAD_CYC - 1);
                        pc_q     <= pc_in;
                        sp_q     <= sp_in;
                        src_q    <= launch.src;
                        run      <= '0;
                    end
                end
                ST_DEAD: begin
                    if (wait_cnt == '0)
                        step <= ST_PUSH_H;
                    else
                        wait_cnt <= wait_cnt - 1'b1;
                end
                ST_PUSH_H, ST_PUSH_L, ST_PUSH_P: begin
                    if (bus_ack) begin
                        sp_q <= sp_q - 8'd1;
                        step <= (step == ST_PUSH_H) ? ST_PUSH_L :
                                (step == ST_PUSH_L) ? ST_PUSH_P : ST_VEC_L;
                    end
                end
                ST_VEC_L: begin
                    if (bus_ack) begin
                        vec_lo <= bus_rdata;
                        step   <= ST_VEC_H;
                    end
                end
                ST_VEC_H: begin
                    if (bus_ack) begin
                        pc_new    <= {bus_rdata, vec_lo};
                        entry_len <= run + 1'b1;
                        step      <= ST_IDLE;
                    end
                end
                default: step <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/irq_seq_status.sv
module irq_seq_status
    import irq_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              so_pin,
    input  logic              entry_done,
    input  logic [BYTE_W-1:0] status_in,
    output logic              status_we,
    output logic [BYTE_W-1:0] status_upd
);

    logic so_prev;
    logic so_fall;

    always_comb begin
        so_fall    = so_prev & ~so_pin;
        status_we  = so_fall | entry_done;
        status_upd = status_in;
        if (so_fall)
            status_upd[FLAG_V] = 1'b1;
        if (entry_done)
            status_upd[FLAG_I] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            so_prev <= 1'b0;
        else
            so_prev <= so_pin;
    end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int         ENTRY_COST = 7,
    parameter logic [7:0] STACK_PAGE = 8'h01,
    parameter int         LEN_W      = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_req,
    input  logic              nmi_line,
    input  logic              so_pin,
    input  logic              boundary,
    input  logic              cli_done,
    input  logic [7:0]        status_in,
    input  logic [15:0]       pc_in,
    input  logic [7:0]        sp_in,
    input  logic              bus_ack,
    input  logic [7:0]        bus_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [15:0]       bus_addr,
    output logic [7:0]        bus_wdata,
    output logic              status_we,
    output logic [7:0]        status_upd,
    output logic [7:0]        sp_new,
    output logic [15:0]       pc_new,
    output logic              entry_done,
    output logic              irq_ack,
    output logic              entry_busy,
    output logic [LEN_W-1:0]  entry_len
);

    launch_t launch;

    irq_seq_arbiter u_arb (
        .clk      (clk),
        .rst      (rst),
        .irq_req  (irq_req),
        .nmi_line (nmi_line),
        .boundary (boundary),
        .cli_done (cli_done),
        .i_flag   (status_in[FLAG_I]),
        .busy     (entry_busy),
        .launch   (launch)
    );

    irq_seq_engine #(
        .ENTRY_COST (ENTRY_COST),
        .STACK_PAGE (STACK_PAGE),
        .LEN_W      (LEN_W)
    ) u_eng (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .pc_in     (pc_in),
        .sp_in     (sp_in),
        .status_in (status_in),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .busy      (entry_busy),
        .done      (entry_done),
        .ack_mask  (irq_ack),
        .pc_new    (pc_new),
        .sp_new    (sp_new),
        .entry_len (entry_len)
    );

    irq_seq_status u_st (
        .clk        (clk),
        .rst        (rst),
        .so_pin     (so_pin),
        .entry_done (entry_done),
        .status_in  (status_in),
        .status_we  (status_we),
        .status_upd (status_upd)
    );

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        so_pin,
    input logic [7:0]  status_in,
    input logic        status_we,
    input logic [7:0]  status_upd,
    input logic        bus_req,
    input logic        bus_we,
    input logic        bus_ack,
    input logic [15:0] bus_addr,
    input logic        entry_done,
    input logic        irq_ack,
    input logic        entry_busy
);

    AST_REQ_IN_ENTRY: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> entry_busy);  // R4

    AST_VEC_AREA: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we) |-> (bus_addr[15:3] == 13'h1FFF));  // R5

    AST_DONE_SETS_I: assert property (@(posedge clk) disable iff (rst)
        entry_done |-> (status_we && status_upd[2]));  // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        entry_done |=> !entry_done);  // R6

    AST_SO_FALL_V: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(so_pin) && !so_pin) |-> (status_we && status_upd[6]));  // R7

    AST_STATUS_KEEP: assert property (@(posedge clk) disable iff (rst)
        status_we |-> ((status_upd & 8'hBB) == (status_in & 8'hBB)));  // R7

    AST_ACK_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> entry_done);  // R8

    AST_STACK_STEP: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && $past(bus_req && bus_we && bus_ack))
        |-> (bus_addr[7:0] == $past(bus_addr[7:0]) - 8'd1)
            && (bus_addr[15:8] == $past(bus_addr[15:8])));  // R10

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr)));  // R12

endmodule

bind irq_entry_seq irq_entry_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .so_pin     (so_pin),
    .status_in  (status_in),
    .status_we  (status_we),
    .status_upd (status_upd),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_ack    (bus_ack),
    .bus_addr   (bus_addr),
    .entry_done (entry_done),
    .irq_ack    (irq_ack),
    .entry_busy (entry_busy)
);

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst, irq_req, nmi_line, so_pin, boundary, cli_done, bus_ack;
    logic [7:0]  status_in, sp_in, bus_rdata;
    logic [15:0] pc_in;
    logic        bus_req, bus_we, status_we, entry_done, irq_ack, entry_busy;
    logic [15:0] bus_addr, pc_new;
    logic [7:0]  bus_wdata, status_upd, sp_new;
    logic [5:0]  entry_len;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] rom(logic [15:0] a);
        case (a)
            16'hFFFA: return 8'h34;
            16'hFFFB: return 8'h12;
            16'hFFFE: return 8'h78;
            16'hFFFF: return 8'h56;
            default:  return 8'hEE;
        endcase
    endfunction

    assign bus_rdata = rom(bus_addr);

    irq_entry_seq dut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .nmi_line(nmi_line),
        .so_pin(so_pin), .boundary(boundary), .cli_done(cli_done),
        .status_in(status_in), .pc_in(pc_in), .sp_in(sp_in),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .status_we(status_we), .status_upd(status_upd), .sp_new(sp_new),
        .pc_new(pc_new), .entry_done(entry_done), .irq_ack(irq_ack),
        .entry_busy(entry_busy), .entry_len(entry_len)
    );

    int n_vec = 0;
    int n_bad = 0;

    // stimulus
    bit          s_rst = 1, s_irq = 0, s_nmi = 0, s_so = 0, s_bnd = 0, s_cli = 0, s_ack = 1;
    logic [15:0] s_pc = 16'h4321;
    logic [7:0]  s_sp = 8'hF0;
    logic [7:0]  core_p = 8'h30;
    logic [7:0]  p_next = 8'h00;
    bit          p_load = 0;

    // reference model state
    int          m_step = 0;
    int          m_run = 0;
    bit          m_nmi_src = 0;
    logic [15:0] m_pc = 0, m_newpc = 0;
    logic [7:0]  m_sp = 0, m_vlo = 0;
    int          m_len = 0;
    bit          m_done = 0, m_ack = 0;
    bit          m_nmi_prev = 0, m_irq_prev = 0, m_so_prev = 0;
    bit          m_nmi_pend = 0, m_irq_pend = 0;

    // observations from the ports
    logic [7:0]  stk [256];
    int          n_nmi = 0, n_irq = 0;
    logic [15:0] last_pc = 0;
    logic [7:0]  last_sp = 0;
    int          last_len = 0;
    bit          obs_busy = 0, obs_req = 0, obs_done = 0;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] m_vec();
        return m_nmi_src ? 16'hFFFA : 16'hFFFE;
    endfunction

    task automatic compare();
        bit          fall, e_we;
        logic [7:0]  e_upd;
        chk("R6", "entry_busy", entry_busy, m_step != 0);
        chk("R4", "bus_req", bus_req, m_step >= 3);
        if (m_step >= 3) begin
            chk("R4", "bus_we", bus_we, m_step <= 5);
            if (m_step <= 5) begin
                chk("R10", "push address", bus_addr, {8'h01, m_sp});
                case (m_step)
                    3: chk("R4", "push pc high", bus_wdata, m_pc[15:8]);
                    4: chk("R4", "push pc low", bus_wdata, m_pc[7:0]);
                    default: chk("R4", "push status", bus_wdata, core_p & 8'hEF);
                endcase
            end else begin
                chk("R5", "vector address", bus_addr, m_vec() | ((m_step == 7) ? 16'h1 : 16'h0));
            end
        end
        chk("R6", "entry_done", entry_done, m_done);
        chk("R8", "irq_ack", irq_ack, m_ack);
        if (m_done) begin
            chk("R5", "pc_new", pc_new, m_newpc);
            chk("R10", "sp_new", sp_new, m_sp);
            chk("R6", "entry_len", entry_len, m_len);
        end
        fall = m_so_prev && !so_pin;
        e_we = fall || m_done;
        e_upd = core_p | (fall ? 8'h40 : 8'h00) | (m_done ? 8'h04 : 8'h00);
        chk("R7", "status_we", status_we, e_we);
        if (e_we) begin
            chk("R7", "status_upd", status_upd, e_upd);
            p_next = e_upd;
            p_load = 1;
        end
    endtask

    task automatic advance();
        bit nrise, irise, check, tnmi, tirq, fin;
        if (s_rst) begin
            m_step = 0; m_run = 0; m_done = 0; m_ack = 0;
            m_nmi_prev = 0; m_irq_prev = 0; m_so_prev = 0;
            m_nmi_pend = 0; m_irq_pend = 0; m_sp = 0; m_pc = 0;
            m_newpc = 0; m_len = 0; m_nmi_src = 0;
            return;
        end
        nrise = nmi_line && !m_nmi_prev;
        irise = irq_req && !m_irq_prev;
        check = boundary && (m_step == 0);
        tnmi  = check && m_nmi_pend;
        tirq  = check && !m_nmi_pend && !cli_done && m_irq_pend && !status_in[2];
        if (check && !m_nmi_pend) m_irq_pend = (cli_done && irq_req) || irise;
        else                      m_irq_pend = m_irq_pend || irise;
        m_nmi_pend = (m_nmi_pend && !tnmi) || nrise;
        m_nmi_prev = nmi_line;
        m_irq_prev = irq_req;
        m_so_prev  = so_pin;
        fin = 0;
        if (m_step != 0) m_run++;
        case (m_step)
            0: if (tnmi || tirq) begin
                   m_step = 1; m_run = 0; m_pc = pc_in; m_sp = sp_in; m_nmi_src = tnmi;
               end
            1, 2: m_step++;
            3, 4, 5: if (bus_ack) begin m_sp = m_sp - 8'd1; m_step++; end
            6: if (bus_ack) begin m_vlo = rom(m_vec()); m_step = 7; end
            default: if (bus_ack) begin
                   m_newpc = {rom(m_vec() | 16'h1), m_vlo};
                   m_len = m_run; fin = 1; m_step = 0;
               end
        endcase
        m_done = fin;
        m_ack  = fin && !m_nmi_src;
    endtask

    task automatic observe();
        obs_busy = entry_busy;
        obs_req  = bus_req;
        obs_done = entry_done;
        if (bus_req && bus_we && bus_ack) stk[bus_addr[7:0]] = bus_wdata;
        if (entry_done) begin
            if (irq_ack) n_irq++; else n_nmi++;
            last_pc  = pc_new;
            last_sp  = sp_new;
            last_len = entry_len;
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        if (p_load) begin core_p = p_next; p_load = 0; end
        rst = s_rst; irq_req = s_irq; nmi_line = s_nmi; so_pin = s_so;
        boundary = s_bnd; cli_done = s_cli; pc_in = s_pc; sp_in = s_sp;
        bus_ack = s_ack; status_in = core_p;
        #1;
        if (!s_rst) compare();
        observe();
        advance();
        s_bnd = 0;
        s_cli = 0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic bnd();
        s_bnd = 1;
        cyc();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) stk[i] = 8'h00;
        rst = 1; irq_req = 0; nmi_line = 0; so_pin = 0; boundary = 0;
        cli_done = 0; bus_ack = 1; status_in = core_p; pc_in = s_pc; sp_in = s_sp;

        run(3);
        s_rst = 0;
        cyc();
        chk("R6", "reset busy", obs_busy, 0);
        chk("R4", "reset bus_req", obs_req, 0);
        chk("R8", "reset done", obs_done, 0);

        // maskable entry, flag clear
        core_p = 8'h30; s_irq = 1;
        run(2); bnd(); run(10);
        chk("R2", "irq entries", n_irq, 1);
        chk("R5", "irq vector pc", last_pc, 16'h5678);
        chk("R4", "stack pc high", stk[8'hF0], 8'h43);
        chk("R4", "stack pc low", stk[8'hEF], 8'h21);
        chk("R4", "stack status B clear", stk[8'hEE], 8'h20);
        chk("R10", "sp after pushes", last_sp, 8'hED);
        chk("R6", "entry length", last_len, 7);
        chk("R5", "I set after entry", core_p[2], 1);
        s_irq = 0; run(2);

        // blocked by flag, then pending lost
        core_p = 8'h34; s_irq = 1;
        run(2); bnd(); run(10);
        chk("R2", "blocked entry", n_irq, 1);
        core_p = 8'h30;
        bnd(); run(10);
        chk("R9", "pending cleared", n_irq, 1);
        s_irq = 0; run(2);

        // one-boundary delay after clearing the flag
        core_p = 8'h34; s_irq = 1;
        run(2);
        core_p = 8'h30; s_cli = 1;
        bnd(); run(1);
        chk("R3", "no entry at clearing boundary", obs_busy, 0);
        run(8);
        chk("R3", "still no entry", n_irq, 1);
        bnd(); run(10);
        chk("R3", "entry at next boundary", n_irq, 2);
        s_irq = 0; run(2);

        // non-maskable held high over several boundaries
        core_p = 8'h34; s_nmi = 1;
        run(1);
        for (int k = 0; k < 3; k++) begin bnd(); run(10); end
        chk("R1", "single nmi entry", n_nmi, 1);
        chk("R5", "nmi vector pc", last_pc, 16'h1234);
        s_nmi = 0; run(2);

        // simultaneous requests
        core_p = 8'h30; s_irq = 1; s_nmi = 1;
        run(1); bnd(); run(10);
        chk("R11", "nmi served first", n_nmi, 2);
        chk("R11", "irq waits", n_irq, 2);
        chk("R11", "first pc", last_pc, 16'h1234);
        core_p = 8'h30;
        bnd(); run(10);
        chk("R11", "irq served after", n_irq, 3);
        chk("R11", "second pc", last_pc, 16'h5678);
        s_irq = 0; s_nmi = 0; run(2);

        // set-overflow pin
        core_p = 8'h81; s_so = 1;
        run(2); s_so = 0; run(2);
        chk("R7", "falling pin sets V", core_p, 8'hC1);
        run(3);
        chk("R7", "low pin no change", core_p, 8'hC1);
        core_p = 8'h81; s_so = 1; run(2);
        chk("R7", "rising pin no change", core_p, 8'h81);
        s_so = 0; run(2);

        // bus stalls
        core_p = 8'h30; s_sp = 8'h02; s_pc = 16'hA5C3; s_irq = 1;
        run(1); bnd();
        for (int k = 0; k < 16; k++) begin s_ack = (k % 3 == 2); cyc(); end
        s_ack = 1; run(8);
        chk("R12", "stalled entry completes", n_irq, 4);
        chk("R12", "length counts stalls", last_len > 7, 1);
        chk("R10", "sp wraps in page", last_sp, 8'hFF);
        chk("R4", "stall push pc low", stk[8'h01], 8'hC3);
        s_irq = 0; run(3);

        finish_run();
    end

endmodule